// File: doc/BRIEF.md
# Speaker and system control port

This block is a byte-wide control and status port that sits next to an interval timer. A write through the port's own address strobe stores four control bits: the gate of timer channel 2, a speaker data enable, and two parity-check disable flags. The stored gate bit drives the gate input of timer channel 2 directly. A read returns the stored control bits together with two live status bits. One is the present OUT level of timer channel 2. The other is a refresh toggle bit that inverts at a fixed programmable interval. The parity error flags read as zero, because parity detection is not part of this block.

The speaker output is set by a small state machine. The machine has four states. In SPK_OFF the data enable is clear and the speaker is silent. In SPK_DIRECT the data enable is set, the gate is clear, and the speaker is held on. In SPK_TONE both enables are set, channel 2 is in a periodic mode, and the speaker follows channel 2 OUT. In SPK_HELD both enables are set but channel 2 is in a one-shot mode, so the speaker is held off.

Every clock the machine moves to the state chosen by the stored bits and the channel-2 mode. The transitions are named as follows:
- go_silent: the data enable is clear.
- go_direct: the data enable is set and the gate is clear.
- go_tone: both enables are set and the mode is periodic.
- go_hold: both enables are set and the mode is one-shot.

Top module: `sysctl_port`

## Requirements
- R1: A write (sel=1, wr=1) stores wdata[3:0] into the control bits on the next rising edge, and wdata[7:4] is ignored. Control bit 0 is the timer-2 gate, bit 1 is the speaker data enable, bit 2 disables the RAM parity check and bit 3 disables the I/O parity check.
- R2: After reset the control bits are 4'b1100, so a read returns 8'h0C when t2_out=0 and the toggle is low.
- R3: While sel=1, rdata[3:0] equals the control bits and rdata[7:6] reads 0.
- R4: While sel=1, rdata[5] equals t2_out in the same cycle.
- R5: While sel=1, rdata[4] is a toggle that starts low after reset and inverts once every REFRESH_DIV clocks.
- R6: t2_gate always equals control bit 0.
- R7: When control bit 1 is clear, spk_out is 0 one clock after the control bits take that value, whatever bit 0 holds.
- R8: When control bit 1 is set and bit 0 is clear, spk_out is 1 one clock later.
- R9: When both bits are set and t2_mode[1]=1 (modes 2, 3, 6 and 7), spk_out follows t2_out from one clock later.
- R10: When both bits are set and t2_mode[1]=0 (modes 0, 1, 4 and 5), spk_out is 0 one clock later.
- R11: While sel=0, rdata is 8'hFF, and a write strobe leaves the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Address strobe for this port |
| wr | input | 1 | Write strobe, qualified by sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 8'hFF when not selected |
| t2_out | input | 1 | OUT level of timer channel 2 |
| t2_mode | input | 3 | Counting mode of timer channel 2 |
| t2_gate | output | 1 | Gate drive for timer channel 2 |
| spk_out | output | 1 | Speaker drive |

## Verification
The assertions assume that t2_mode and the strobes change only between clock edges and hold steady across each edge. The speaker checks also assume that a control value stays in place for at least one clock, so the state can follow it. The bench meets these assumptions in two ways. It drives every input just after a falling edge. It also holds each written value for two edges before it samples. Channel-2 OUT is toggled only while the port is in a stable state, so the output can be compared within the same cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    typedef enum logic [1:0] {
        SPK_OFF    = 2'd0,
        SPK_DIRECT = 2'd1,
        SPK_TONE   = 2'd2,
        SPK_HELD   = 2'd3
    } spk_state_t;

    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 4'b1100;
endpackage

// File: rtl/sysctl_refresh_tgl.sv
module sysctl_refresh_tgl #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tgl
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tgl <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            tgl <= ~tgl;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The toggle may only flip after a full interval has been counted.
    p_toggle_interval_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl != $past(tgl)) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [CTRL_W-1:0] ctrl
);
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl <= CTRL_RESET;
        else if (wr_en) ctrl <= wdata[CTRL_W-1:0];
    end

    p_write_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl == $past(wdata[3:0])));
    p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
endmodule

// File: rtl/sysctl_spk_fsm.sv
module sysctl_spk_fsm
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_en,
    input  logic       data_en,
    input  logic [2:0] t2_mode,
    input  logic       t2_out,
    output logic       spk_out
);
    spk_state_t state, state_nx;
    logic periodic;

    assign periodic = t2_mode[1];

    always_comb begin
        unique case ({data_en, gate_en})
            2'b00, 2'b01: state_nx = SPK_OFF;                    // go_silent
            2'b10:        state_nx = SPK_DIRECT;                 // go_direct
            2'b11:        state_nx = periodic ? SPK_TONE : SPK_HELD; // go_tone / go_hold
            default:      state_nx = SPK_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SPK_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            SPK_OFF:    spk_out = 1'b0;
            SPK_DIRECT: spk_out = 1'b1;
            SPK_TONE:   spk_out = t2_out;
            SPK_HELD:   spk_out = 1'b0;
            default:    spk_out = 1'b0;
        endcase
    end

    p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> !spk_out);
    p_direct_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && !gate_en) |=> spk_out);
    p_oneshot_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && gate_en && !t2_mode[1]) |=> !spk_out);
    p_tone_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && gate_en && t2_mode[1]) |=> (spk_out == t2_out));
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int REFRESH_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       t2_out,
    input  logic [2:0] t2_mode,
    output logic       t2_gate,
    output logic       spk_out
);
    logic [CTRL_W-1:0] ctrl;
    logic              refresh_tgl;

    sysctl_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel & wr),
        .wdata (wdata),
        .ctrl  (ctrl)
    );

    sysctl_refresh_tgl #(.DIV(REFRESH_DIV)) u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl   (refresh_tgl)
    );

    sysctl_spk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (ctrl[0]),
        .data_en (ctrl[1]),
        .t2_mode (t2_mode),
        .t2_out  (t2_out),
        .spk_out (spk_out)
    );

    assign t2_gate = ctrl[0];
    assign rdata   = sel ? {2'b00, t2_out, refresh_tgl, ctrl} : 8'hFF;

    p_gate_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> (t2_gate == $past(wdata[0])));
    p_status_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (rdata[5] == t2_out && rdata[7:6] == 2'b00));
endmodule

// File: tb/sysctl_port_test.sv
module sysctl_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       t2_out = 1'b0;
    logic [2:0] t2_mode = 3'd0;
    logic       t2_gate;
    logic       spk_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sysctl_port uut (.*);

    // {wdata[7:0], mode[2:0], t2_out, expected speaker}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {8'hF3, 3'd3, 1'b1, 1'b1},
        {8'hF3, 3'd3, 1'b0, 1'b0},
        {8'h03, 3'd2, 1'b1, 1'b1},
        {8'h03, 3'd0, 1'b1, 1'b0},
        {8'h03, 3'd5, 1'b1, 1'b0},
        {8'h03, 3'd6, 1'b1, 1'b1},
        {8'h02, 3'd0, 1'b0, 1'b1},
        {8'h0A, 3'd3, 1'b1, 1'b1},
        {8'h01, 3'd3, 1'b1, 1'b0},
        {8'h05, 3'd2, 1'b1, 1'b0},
        {8'h0C, 3'd3, 1'b1, 1'b0},
        {8'hA0, 3'd3, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v, input logic strobe);
        @(negedge clk);
        sel = strobe; wr = 1'b1; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    function automatic string spk_req(input logic [1:0] c, input logic [2:0] m);
        if (!c[1])      return "R7";
        else if (!c[0]) return "R8";
        else if (m[1])  return "R9";
        else            return "R10";
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sel = 1'b1;
        #1;
        check("R2", rdata, 8'h0C);
        check("R6", {7'd0, t2_gate}, 8'h00);
        check("R7", {7'd0, spk_out}, 8'h00);
        sel = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [7:0] w;
            logic [2:0] m;
            logic [1:0] c;
            w = VEC[i][12:5];
            m = VEC[i][4:2];
            c = w[1:0];
            t2_mode = m;
            t2_out = VEC[i][1];
            do_write(w, 1'b1);
            @(negedge clk);
            sel = 1'b1;
            #1;
            check("R1", {4'd0, rdata[3:0]}, {4'd0, w[3:0]});
            check("R3", {6'd0, rdata[7:6]}, 8'h00);
            check("R4", {7'd0, rdata[5]}, {7'd0, t2_out});
            check("R6", {7'd0, t2_gate}, {7'd0, w[0]});
            check(spk_req(c, m), {7'd0, spk_out}, {7'd0, VEC[i][0]});
            sel = 1'b0;
        end

        // R9: in tone state the speaker follows OUT in the same cycle
        t2_mode = 3'd3;
        do_write(8'h03, 1'b1);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            t2_out = k[0];
            #1;
            check("R9", {7'd0, spk_out}, {7'd0, k[0]});
            sel = 1'b1; #1;
            check("R4", {7'd0, rdata[5]}, {7'd0, k[0]});
            sel = 1'b0;
            @(negedge clk);
        end

        // R11: unselected read and ignored write
        do_write(8'h0C, 1'b1);
        #1;
        check("R11", rdata, 8'hFF);
        do_write(8'h03, 1'b0);
        @(negedge clk);
        sel = 1'b1; #1;
        check("R11", {4'd0, rdata[3:0]}, 8'h0C);
        check("R11", {7'd0, t2_gate}, 8'h00);

        // R5: toggle interval equals the default REFRESH_DIV of 16
        begin
            logic prev;
            int n;
            prev = rdata[4];
            while (rdata[4] == prev) @(negedge clk);
            prev = rdata[4];
            n = 0;
            while (rdata[4] == prev && n < 100) begin
                @(negedge clk);
                n++;
            end
            check("R5", 8'(n), 8'd16);
        end
        sel = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule